// File: doc/BRIEF.md
# Output Compare Channel with Software-Forced Levels

This block is one output compare channel for a timer. It compares a free-running counter value, supplied from outside, against a shadow copy of a compare value. From the result it builds an active-high reference waveform and a pin output whose polarity can be set. A 3-bit mode field selects how the reference reacts to a compare match: hold, set, clear or toggle. Two further codes ignore the comparison and force the reference to its active or inactive level.

Forcing the level does not stop the comparison. A counter value equal to the shadow compare value still raises a sticky match flag in every mode. That flag feeds separately gated interrupt and DMA request lines, so software can time events while it holds the pin at a fixed level. A software event strobe can also raise the flag.

The compare value is written through a write strobe. When preload is off, a written value takes effect on the next clock. When preload is on, it waits in a holding register until the next counter overflow pulse.

Top module: `occh_top`

## Requirements
- R1: The channel acts as an output only when `chan_sel` equals 2'b00. With any other value, the reference holds its value, counter equality does not set the flag, and `oc_pin` is 0.
- R2: Mode 3'b101 forces `oc_ref` to 1 on the next clock edge, whatever the comparison gives.
- R3: Mode 3'b100 forces `oc_ref` to 0 on the next clock edge, whatever the comparison gives.
- R4: Mode 3'b000 holds `oc_ref` at its value, including on compare matches. The unused codes 3'b110 and 3'b111 also hold it.
- R5: On a compare match, mode 3'b001 sets `oc_ref` to 1, mode 3'b010 clears it to 0, and mode 3'b011 inverts it. Each change appears after the clock edge of the match cycle. Without a match these modes hold `oc_ref`.
- R6: When `out_en` is 1 and the channel is an output, `oc_pin` equals `oc_ref` XOR `pol`: active high when `pol` is 0, inverted when `pol` is 1. When `out_en` is 0, `oc_pin` is 0.
- R7: A cycle in which `cnt_val` equals the shadow compare value sets `match_flag` after that clock edge, in every mode, the forced ones included. The flag stays set until a `flag_clr` pulse. If a set and a clear arrive in the same cycle, the set wins.
- R8: A pulse on `evt_gen` sets `match_flag` after the clock edge and leaves `oc_ref` unchanged.
- R9: `irq_req` equals `match_flag` AND `irq_en`, and `dma_req` equals `match_flag` AND `dma_en`.
- R10: With `preload_en` at 0, a `cmp_wr` pulse loads the shadow compare value on the same edge. With `preload_en` at 1, a written value goes to a holding register and moves into the shadow only on an edge where `cnt_ovf` is 1.
- R11: After reset, `oc_ref`, `match_flag` and the shadow compare value are 0. Reset is asserted asynchronously and released synchronously, two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CW | Current counter value |
| cnt_ovf | input | 1 | Counter overflow pulse (preload transfer point) |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CW | Compare value to write |
| preload_en | input | 1 | 1: buffer writes until overflow |
| chan_sel | input | 2 | Channel direction select, 2'b00 = output |
| mode | input | 3 | Reference behaviour code |
| pol | input | 1 | Pin polarity, 1 = inverted |
| out_en | input | 1 | Pin enable |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable |
| evt_gen | input | 1 | Software event: set match flag |
| flag_clr | input | 1 | Software clear of match flag |
| oc_ref | output | 1 | Active-high reference waveform |
| oc_pin | output | 1 | Polarity-adjusted, enabled pin level |
| match_flag | output | 1 | Sticky compare-match flag |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
Directed sequences apply each of the six defined modes while the counter both hits and misses the shadow value. This separates the forced codes, which must ignore equality for the reference yet still raise the flag, from the match-driven codes. Preload runs are ordered so that a value held in the holding register cannot match before an overflow pulse, while a direct write matches on the very next cycle. A random phase then mixes small counter and compare values, so that matches occur often, with random modes, polarity, enables, clear and event strobes. Within this phase, set-versus-clear collisions and non-output channel selects occur often enough to be exercised.

// File: rtl/occh_pkg.sv
package occh_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN   = 3'b000,
    OCM_SET      = 3'b001,
    OCM_CLEAR    = 3'b010,
    OCM_TOGGLE   = 3'b011,
    OCM_FORCE_LO = 3'b100,
    OCM_FORCE_HI = 3'b101,
    OCM_RSVD6    = 3'b110,
    OCM_RSVD7    = 3'b111
  } oc_mode_e;

  localparam logic [1:0] SEL_OUTPUT = 2'b00;

endpackage

// File: rtl/occh_rstsync.sv
module occh_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/occh_shadow.sv
module occh_shadow #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          preload_en,
  input  logic          cnt_ovf,
  output logic [CW-1:0] shadow
);

  logic [CW-1:0] hold_q, hold_d;
  logic [CW-1:0] shadow_q, shadow_d;
  logic          hold_en, shadow_en;

  // holding register captures every write
  always_comb begin
    hold_en = cmp_wr;
    hold_d  = cmp_wdata;
  end

  // shadow: direct when preload off, transfer on overflow when on
  always_comb begin
    shadow_en = 1'b0;
    shadow_d  = shadow_q;
    if (!preload_en) begin
      if (cmp_wr) begin
        shadow_en = 1'b1;
        shadow_d  = cmp_wdata;
      end
    end else if (cnt_ovf) begin
      shadow_en = 1'b1;
      shadow_d  = hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end

  assign shadow = shadow_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_en && !cnt_ovf) |=> $stable(shadow_q)); // R10
  AST_SHADOW_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!preload_en && cmp_wr) |=> (shadow_q == $past(cmp_wdata))); // R10

endmodule

// File: rtl/occh_refgen.sv
module occh_refgen
  import occh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     is_out,
  input  oc_mode_e mode,
  input  logic     match,
  output logic     oc_ref
);

  logic ref_q, ref_d, ref_en;

  always_comb begin
    ref_d = ref_q;
    unique case (mode)
      OCM_FORCE_HI: ref_d = 1'b1;
      OCM_FORCE_LO: ref_d = 1'b0;
      OCM_SET:      if (match) ref_d = 1'b1;
      OCM_CLEAR:    if (match) ref_d = 1'b0;
      OCM_TOGGLE:   if (match) ref_d = ~ref_q;
      default:      ref_d = ref_q;
    endcase
    ref_en = is_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= 1'b0;
    else if (ref_en) ref_q <= ref_d;
  end

  assign oc_ref = ref_q;

  AST_NOT_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !is_out |=> $stable(ref_q)); // R1
  AST_FORCE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out && mode == OCM_FORCE_HI) |=> ref_q); // R2
  AST_FORCE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out && mode == OCM_FORCE_LO) |=> !ref_q); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OCM_FROZEN) |=> $stable(ref_q)); // R4
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out && mode == OCM_TOGGLE && match) |=> (ref_q != $past(ref_q))); // R5

endmodule

// File: rtl/occh_flag.sv
module occh_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic evt_gen,
  input  logic flag_clr,
  input  logic irq_en,
  input  logic dma_en,
  output logic match_flag,
  output logic irq_req,
  output logic dma_req
);

  logic flag_q, flag_d, flag_en;
  logic set_req;

  always_comb begin
    set_req = match | evt_gen;
    flag_en = set_req | flag_clr;
    flag_d  = set_req ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign match_flag = flag_q;
  assign irq_req    = flag_q & irq_en;
  assign dma_req    = flag_q & dma_en;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R7
  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_gen |=> flag_q); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match && !evt_gen) |=> !flag_q); // R7

endmodule

// File: rtl/occh_top.sv
module occh_top
  import occh_pkg::*;
#(
  parameter int CW = 16,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          preload_en,
  input  logic [1:0]    chan_sel,
  input  logic [2:0]    mode,
  input  logic          pol,
  input  logic          out_en,
  input  logic          irq_en,
  input  logic          dma_en,
  input  logic          evt_gen,
  input  logic          flag_clr,
  output logic          oc_ref,
  output logic          oc_pin,
  output logic          match_flag,
  output logic          irq_req,
  output logic          dma_req
);

  logic          rst_i_n;
  logic [CW-1:0] shadow;
  logic          is_out;
  logic          match;

  occh_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  occh_shadow #(.CW(CW)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .cmp_wr     (cmp_wr),
    .cmp_wdata  (cmp_wdata),
    .preload_en (preload_en),
    .cnt_ovf    (cnt_ovf),
    .shadow     (shadow)
  );

  always_comb begin
    is_out = (chan_sel == SEL_OUTPUT);
    match  = is_out && (cnt_val == shadow);
  end

  occh_refgen u_ref (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .is_out (is_out),
    .mode   (oc_mode_e'(mode)),
    .match  (match),
    .oc_ref (oc_ref)
  );

  occh_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .match      (match),
    .evt_gen    (evt_gen),
    .flag_clr   (flag_clr),
    .irq_en     (irq_en),
    .dma_en     (dma_en),
    .match_flag (match_flag),
    .irq_req    (irq_req),
    .dma_req    (dma_req)
  );

  always_comb begin
    oc_pin = (out_en && is_out) ? (oc_ref ^ pol) : 1'b0;
  end

  AST_EVT_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_i_n)
    (evt_gen && is_out && mode == 3'b000) |=> $stable(oc_ref)); // R8
  AST_NO_FLAG_AS_INPUT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!is_out && !evt_gen && !match_flag) |=> !match_flag); // R1

endmodule

// File: tb/sim_occh_top.sv
`timescale 1ns/1ps
module sim_occh_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt_val, cmp_wdata;
  logic          cnt_ovf, cmp_wr, preload_en, pol, out_en, irq_en, dma_en, evt_gen, flag_clr;
  logic [1:0]    chan_sel;
  logic [2:0]    mode;
  logic          oc_ref, oc_pin, match_flag, irq_req, dma_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic          m_ref, m_flag;
  logic [CW-1:0] m_shadow, m_hold;

  always #2.5 clk = ~clk;

  occh_top #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .preload_en(preload_en),
    .chan_sel(chan_sel), .mode(mode), .pol(pol), .out_en(out_en),
    .irq_en(irq_en), .dma_en(dma_en), .evt_gen(evt_gen), .flag_clr(flag_clr),
    .oc_ref(oc_ref), .oc_pin(oc_pin), .match_flag(match_flag),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  function automatic logic next_ref(input logic cur, input logic [2:0] md, input logic hit);
    case (md)
      3'b101: return 1'b1;
      3'b100: return 1'b0;
      3'b001: return hit ? 1'b1 : cur;
      3'b010: return hit ? 1'b0 : cur;
      3'b011: return hit ? ~cur : cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic exp_pin(input logic r);
    return (out_en && chan_sel == 2'b00) ? (r ^ pol) : 1'b0;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic is_o, hit;
    @(posedge clk);
    is_o = (chan_sel == 2'b00);
    hit  = is_o && (cnt_val == m_shadow);
    if (is_o) m_ref = next_ref(m_ref, mode, hit);
    if (hit || evt_gen) m_flag = 1'b1;
    else if (flag_clr)  m_flag = 1'b0;
    if (!preload_en) begin
      if (cmp_wr) m_shadow = cmp_wdata;
    end else if (cnt_ovf) m_shadow = m_hold;
    if (cmp_wr) m_hold = cmp_wdata;
    #1;
    chk(tag, "oc_ref", oc_ref, m_ref);
    chk(tag, "oc_pin", oc_pin, exp_pin(m_ref));
    chk(tag, "match_flag", match_flag, m_flag);
    chk(tag, "irq_req", irq_req, m_flag & irq_en);
    chk(tag, "dma_req", dma_req, m_flag & dma_en);
  endtask

  task automatic idle();
    cnt_ovf = 0; cmp_wr = 0; evt_gen = 0; flag_clr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE));
    rst_n = 0; cnt_val = '1; cmp_wdata = '0; idle();
    preload_en = 0; chan_sel = 2'b01; mode = 3'b000; pol = 0;
    out_en = 0; irq_en = 0; dma_en = 0;
    m_ref = 0; m_flag = 0; m_shadow = '0; m_hold = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R11", "oc_ref", oc_ref, 1'b0);
    chk("R11", "match_flag", match_flag, 1'b0);
    chk("R11", "oc_pin", oc_pin, 1'b0);
    // shadow is 0 after reset: a zero counter matches
    chan_sel = 2'b00; cnt_val = '0; step("R11");
    flag_clr = 1; cnt_val = '1; step("R7");
    idle();

    // direct write, forced high, polarity
    cmp_wr = 1; cmp_wdata = 16'd5; step("R10");
    idle(); mode = 3'b101; out_en = 1; step("R2");
    pol = 1; step("R6");
    irq_en = 1; dma_en = 1; cnt_val = 16'd5; step("R7");
    cnt_val = 16'd6; step("R9");
    flag_clr = 1; step("R7");
    flag_clr = 1; cnt_val = 16'd5; step("R7");
    idle();
    // forced low, match still flags
    flag_clr = 1; cnt_val = 16'd6; step("R3");
    idle(); mode = 3'b100; cnt_val = 16'd5; step("R3");
    step("R3");
    // frozen on a match
    mode = 3'b101; step("R2");
    mode = 3'b000; step("R4");
    mode = 3'b110; step("R4");
    // toggle, clear, set
    mode = 3'b011; step("R5");
    step("R5");
    cnt_val = 16'd2; step("R5");
    mode = 3'b010; cnt_val = 16'd5; step("R5");
    mode = 3'b001; cnt_val = 16'd2; step("R5");
    cnt_val = 16'd5; step("R5");
    // event strobe
    mode = 3'b000; flag_clr = 1; cnt_val = 16'd1; step("R8");
    idle(); evt_gen = 1; step("R8");
    idle(); step("R8");
    // preload
    flag_clr = 1; preload_en = 1; cmp_wr = 1; cmp_wdata = 16'd9; step("R10");
    idle(); cnt_val = 16'd9; step("R10");
    step("R10");
    cnt_ovf = 1; cnt_val = 16'd3; step("R10");
    cnt_ovf = 0; cnt_val = 16'd9; step("R10");
    // not an output
    flag_clr = 1; cnt_val = 16'd1; step("R1");
    idle(); chan_sel = 2'b10; mode = 3'b100; cnt_val = 16'd9; step("R1");
    step("R1");
    chan_sel = 2'b00; out_en = 0; mode = 3'b101; step("R6");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      chan_sel   = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'b00;
      mode       = 3'($urandom % 8);
      cnt_val    = CW'($urandom % 8);
      cmp_wr     = ($urandom % 6 == 0);
      cmp_wdata  = CW'($urandom % 8);
      if ($urandom % 50 == 0) preload_en = ~preload_en;
      cnt_ovf    = ($urandom % 5 == 0);
      evt_gen    = ($urandom % 10 == 0);
      flag_clr   = ($urandom % 4 == 0);
      pol        = 1'($urandom);
      out_en     = ($urandom % 4 != 0);
      irq_en     = 1'($urandom);
      dma_en     = 1'($urandom);
      step("R7");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule